// File: doc/BRIEF.md
# Bus Command Mailbox

This block sits on the slave side of a system bus and lets other bus modules hand a command to the local processor. A bus write that is addressed to this module and whose low address byte has its three top bits clear is taken as a command. The block latches the 32-bit write data, address bits 15 to 8 of that write, and one extra data byte that travels with the transfer. It then raises an interrupt to the local processor.

The processor collects the command through a small read port with two read-only registers. The command register returns the latched data word. The status register returns the side information, the slot number, a pending bit and an overrun flag. Reading the command register acknowledges the interrupt. If a second command arrives before the first has been read, it overwrites the first and sets a sticky overrun flag, which a status read clears.

Top module: `cmd_mailbox`

## Requirements
- R1: A cycle with `bus_sel`=1 and `bus_wr`=1 whose `bus_addr[7:5]` is 000 is accepted as a command; `bus_addr[31:8]` and `bus_addr[4:0]` have no effect on the decision.
- R2: A cycle with `bus_addr[7:5]` not 000, or with `bus_sel`=0, or with `bus_wr`=0 is ignored: no interrupt is raised and every captured value is unchanged.
- R3: A read with `cpu_rd_sel`=0 (command register) returns the 32-bit `bus_wdata` of the most recently accepted command.
- R4: Status bits 15:8 (`cpu_rd_sel`=1) hold `bus_addr[15:8]` of the most recently accepted command.
- R5: Status bits 23:16 hold `bus_xbyte` of the most recently accepted command.
- R6: Status bits 27:24 hold the `slot_id` input as sampled on the read cycle; status bits 31:29 and 7:1 read as zero.
- R7: `cmd_irq` rises on the clock edge that accepts a command and stays high until a command register read; status bit 0 mirrors it.
- R8: A command register read clears `cmd_irq` on its clock edge, unless a command is accepted in the same cycle, in which case `cmd_irq` stays high and the read returns the older command.
- R9: A command accepted while `cmd_irq` is high and no command read occurs in that cycle sets the overrun flag (status bit 28); the flag stays set until a status read, which clears it unless a new overrun occurs in the same cycle.
- R10: `cpu_rdata` is registered: it shows the selected register, as it stood before that edge's updates, from the edge where `cpu_rd_en`=1 and holds it until the next read.
- R11: After reset the captured values, `cmd_irq`, the overrun flag and `cpu_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus transfer addressed to this module in this cycle |
| bus_wr | input | 1 | Transfer is a write |
| bus_addr | input | 32 | Bus address |
| bus_wdata | input | 32 | Bus write data word |
| bus_xbyte | input | 8 | Extra data byte carried with the transfer |
| slot_id | input | 4 | Backplane slot number |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_rd_sel | input | 1 | 0 = command register, 1 = status register |
| cpu_rdata | output | 32 | Registered read data |
| cmd_irq | output | 1 | Command-arrived interrupt |

## Verification
A wrong decode shows one edge after the write as an interrupt that rises or fails to rise, and on the next read as a command word that does or does not change. A lost or spurious pending state appears on `cmd_irq` right away and in status bit 0 on the next status read, while a mishandled overrun shows only through status bit 28 and only on the following status read, so the bench reads status twice around each overrun. Collisions of a command with a same-cycle read are driven on purpose, since a wrong priority there changes both the interrupt and the returned word within one cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_DATA_W = 32;
    localparam int unsigned MBX_BYTE_W = 8;
    localparam int unsigned MBX_SLOT_W = 4;

    // status register field positions (processor software decodes these)
    localparam int unsigned ST_PEND_BIT = 0;
    localparam int unsigned ST_ABYTE_LO = 8;
    localparam int unsigned ST_XBYTE_LO = 16;
    localparam int unsigned ST_SLOT_LO  = 24;
    localparam int unsigned ST_OVR_BIT  = 28;

    typedef enum logic {
        RSEL_CMD  = 1'b0,
        RSEL_STAT = 1'b1
    } rsel_e;

    typedef struct packed {
        logic [MBX_DATA_W-1:0] cmd;
        logic [MBX_BYTE_W-1:0] abyte;
        logic [MBX_BYTE_W-1:0] xbyte;
        logic                  pend;
        logic                  ovr;
    } mbx_state_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LOW_W    = 8,
    parameter int unsigned DEC_BITS = 3
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              accept
);
    localparam int unsigned TOP = LOW_W - 1;
    localparam int unsigned BOT = LOW_W - DEC_BITS;

    logic field_clear;

    generate
        if (DEC_BITS == 0) begin : g_nodec
            assign field_clear = 1'b1;
        end else begin : g_dec
            assign field_clear = (bus_addr[TOP:BOT] == '0);
        end
    endgenerate

    assign accept = bus_sel & bus_wr & field_clear;
endmodule

// File: rtl/mbx_capture.sv
module mbx_capture
    import mbx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic [MBX_DATA_W-1:0] cmd_in,
    input  logic [MBX_BYTE_W-1:0] abyte_in,
    input  logic [MBX_BYTE_W-1:0] xbyte_in,
    input  logic                  rd_cmd,
    input  logic                  rd_stat,
    output mbx_state_t            st_q
);
    mbx_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.cmd   = cmd_in;
            st_d.abyte = abyte_in;
            st_d.xbyte = xbyte_in;
            st_d.pend  = 1'b1;
        end else if (rd_cmd) begin
            st_d.pend = 1'b0;
        end
        if (accept && st_q.pend && !rd_cmd) begin
            st_d.ovr = 1'b1;
        end else if (rd_stat) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r7_irq_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st_q.pend);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !accept) |=> !st_q.pend);
    a_r2_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(st_q.cmd) && $stable(st_q.abyte) && $stable(st_q.xbyte));
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.pend && !rd_cmd) |=> st_q.ovr);
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !rd_stat) |=> st_q.ovr);
endmodule

// File: rtl/mbx_readport.sv
module mbx_readport
    import mbx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  rsel_e                 rd_sel,
    input  mbx_state_t            st,
    input  logic [MBX_SLOT_W-1:0] slot,
    output logic [MBX_DATA_W-1:0] rdata_q
);
    logic [MBX_DATA_W-1:0] rdata_d;
    logic [MBX_DATA_W-1:0] status_w;

    always_comb begin
        status_w = '0;
        status_w[ST_PEND_BIT]                         = st.pend;
        status_w[ST_ABYTE_LO +: MBX_BYTE_W]           = st.abyte;
        status_w[ST_XBYTE_LO +: MBX_BYTE_W]           = st.xbyte;
        status_w[ST_SLOT_LO  +: MBX_SLOT_W]           = slot;
        status_w[ST_OVR_BIT]                          = st.ovr;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            rdata_d = (rd_sel == RSEL_CMD) ? st.cmd : status_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [7:0]  bus_xbyte,
    input  logic [3:0]  slot_id,
    input  logic        cpu_rd_en,
    input  logic        cpu_rd_sel,
    output logic [31:0] cpu_rdata,
    output logic        cmd_irq
);
    localparam int unsigned ADDR_W = 32;

    logic       accept;
    logic       rd_cmd;
    logic       rd_stat;
    rsel_e      rsel;
    mbx_state_t st_q;

    assign rsel    = rsel_e'(cpu_rd_sel);
    assign rd_cmd  = cpu_rd_en && (rsel == RSEL_CMD);
    assign rd_stat = cpu_rd_en && (rsel == RSEL_STAT);

    mbx_decode #(.ADDR_W(ADDR_W), .LOW_W(8), .DEC_BITS(3)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .accept   (accept)
    );

    mbx_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cmd_in   (bus_wdata),
        .abyte_in (bus_addr[15:8]),
        .xbyte_in (bus_xbyte),
        .rd_cmd   (rd_cmd),
        .rd_stat  (rd_stat),
        .st_q     (st_q)
    );

    mbx_readport u_rp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (cpu_rd_en),
        .rd_sel  (rsel),
        .st      (st_q),
        .slot    (slot_id),
        .rdata_q (cpu_rdata)
    );

    assign cmd_irq = st_q.pend;

    a_r1_irq_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_irq) |-> $past(bus_sel && bus_wr));
    a_r2_bad_addr_no_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_irq && bus_addr[7:5] != 3'b000) |=> !cmd_irq);
endmodule

// File: tb/sim_cmd_mailbox.sv
`timescale 1ns/100ps
module sim_cmd_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  bus_xbyte = '0;
    logic [3:0]  slot_id = 4'h0;
    logic        cpu_rd_en = 1'b0;
    logic        cpu_rd_sel = 1'b0;
    logic [31:0] cpu_rdata;
    logic        cmd_irq;

    always #2.5 clk = ~clk;

    cmd_mailbox u0 (.*);

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    // reference model
    logic [31:0] m_cmd = '0;
    logic [7:0]  m_ab = '0, m_xb = '0;
    logic        m_pend = 0, m_ovr = 0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sbq[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one item per registered read
    logic rd_seen = 0;
    always @(posedge clk) rd_seen <= cpu_rd_en;
    always @(negedge clk) begin
        if (rd_seen && rst_n) begin
            if (sbq.size() == 0) begin
                nvec++; nerr++;
                $display("FAIL R10 actual=unexpected read expected=none");
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(it.tag, cpu_rdata, it.exp);
            end
        end
    end

    function automatic logic [31:0] stat_exp();
        return {3'b000, m_ovr, slot_id, m_xb, m_ab, 7'b0, m_pend};
    endfunction

    // one cycle of stimulus, entered and left at a negedge
    task automatic cyc(input bit wr, input bit sel, input logic [31:0] addr,
                       input logic [31:0] data, input logic [7:0] xb,
                       input bit rd, input bit rsel, input string tag);
        bit acc, rdc, rds;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = data; bus_xbyte = xb;
        cpu_rd_en = rd; cpu_rd_sel = rsel;
        acc = sel && wr && (addr[7:5] == 3'b000);
        rdc = rd && !rsel;
        rds = rd && rsel;
        if (rd) begin
            item_t it;
            it.exp = rsel ? stat_exp() : m_cmd;
            it.tag = tag;
            sbq.push_back(it);
        end
        if (acc && m_pend && !rdc) m_ovr = 1;
        else if (rds) m_ovr = 0;
        if (acc) begin
            m_cmd = data; m_ab = addr[15:8]; m_xb = xb; m_pend = 1;
        end else if (rdc) m_pend = 0;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; cpu_rd_en = 0;
        check({tag, " irq"}, {31'b0, cmd_irq}, {31'b0, m_pend});
    endtask

    task automatic wr_cmd(input bit sel, input bit wr, input logic [31:0] a,
                          input logic [31:0] d, input logic [7:0] x, input string tag);
        cyc(wr, sel, a, d, x, 0, 0, tag);
    endtask

    task automatic rd(input bit rsel, input string tag);
        cyc(0, 0, '0, '0, '0, 1, rsel, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rdata", cpu_rdata, 32'h0);
        check("R11 irq", {31'b0, cmd_irq}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        slot_id = 4'h9;
        rd(1, "R11 R6 status after reset");
        rd(0, "R11 cmd after reset");

        // R1 R3 R4 R5 R7 basic command
        wr_cmd(1, 1, 32'hFFFF_3A1F, 32'hDEAD_BEEF, 8'h5C, "R1 R7 accept");
        rd(1, "R4 R5 R6 R7 status");
        rd(0, "R3 R8 cmd read");
        rd(1, "R7 status pend cleared");

        // R2 ignored writes: each decode bit, no select, no write
        wr_cmd(1, 1, 32'h0000_1220, 32'h1111_1111, 8'h11, "R2 addr bit5");
        wr_cmd(1, 1, 32'h0000_1240, 32'h2222_2222, 8'h22, "R2 addr bit6");
        wr_cmd(1, 1, 32'h0000_1280, 32'h3333_3333, 8'h33, "R2 addr bit7");
        wr_cmd(1, 1, 32'h0000_12E0, 32'h4444_4444, 8'h44, "R2 addr all");
        wr_cmd(0, 1, 32'h0000_1200, 32'h5555_5555, 8'h55, "R2 no select");
        wr_cmd(1, 0, 32'h0000_1200, 32'h6666_6666, 8'h66, "R2 read cycle");
        rd(0, "R2 cmd unchanged");
        rd(1, "R2 status unchanged");

        // R1 don't-care bits, several patterns
        for (int i = 0; i < 6; i++) begin
            logic [31:0] a;
            a = {8'(i * 37 + 5), 8'(8'hA0 + i), 8'(i * 19), 3'b000, 5'(i * 7)};
            wr_cmd(1, 1, a, 32'h0100_0000 * i + 32'h0013_57 * i, 8'(i * 9 + 1), "R1 pattern");
            rd(1, "R4 R5 pattern status");
            rd(0, "R3 pattern cmd");
        end

        // R9 overrun
        wr_cmd(1, 1, 32'h0000_0100, 32'hAAAA_0001, 8'h01, "R9 first");
        wr_cmd(1, 1, 32'h0000_0200, 32'hAAAA_0002, 8'h02, "R9 second");
        rd(0, "R9 cmd is newest");
        rd(1, "R9 overrun visible");
        rd(1, "R9 overrun cleared by status read");

        // R8 collision: command read and new command same cycle
        wr_cmd(1, 1, 32'h0000_0300, 32'hBBBB_0001, 8'h03, "R8 setup");
        cyc(1, 1, 32'h0000_0400, 32'hBBBB_0002, 8'h04, 1, 0, "R8 R10 read returns older");
        rd(1, "R8 no overrun on collision");
        // R9 overrun and status read same cycle: set wins, read shows old
        cyc(1, 1, 32'h0000_0500, 32'hCCCC_0001, 8'h05, 1, 1, "R9 R10 status old value");
        rd(1, "R9 set beats clear");
        slot_id = 4'h3;
        rd(1, "R6 slot follows input");
        rd(0, "R3 final cmd");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            nvec++; nerr++;
            $display("FAIL R10 actual=%0d pending reads expected=0", sbq.size());
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nvec++; nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule